// File: doc/BRIEF.md
# Reset Cause Status Register

This block records why the chip last came out of reset. It holds two sticky cause flags. One marks a watchdog/timer underflow. The other marks a global software reset. Each flag is set by a one-cycle event from its source logic. Software can read the flags over a simple synchronous peripheral bus, and it can clear a flag by writing 0 to it. Software can never set a flag. Only the external chip reset clears the flags unconditionally. The global software reset and the watchdog reset do not reach the flag storage, so a flag can still be read after the reset it records.

The block also qualifies the global software reset request. A write to the control offset produces the one-cycle reset request only when the core-enable bit and the host-reset bit are both set in the same write. A write that sets only the software-request bit records the cause flag and produces no reset.

Top module: `rst_cause_reg`

## Requirements
- R1: While `ext_rst` is high at a clock edge, both flags, `bus_rdata` and `glob_rst_req` become 0.
- R2: A cycle with `wdt_underflow` high sets the watchdog flag (status bit 0) at that clock edge. The flag then stays 1 until it is cleared.
- R3: A write to the control offset (0x14) with data bits 1 (core enable) and 2 (host reset) both 1 drives `glob_rst_req` high for exactly the one cycle after the write edge. The same write sets the software-reset flag (status bit 1).
- R4: A control write with only one of data bits 1 and 2 set leaves `glob_rst_req` low. If data bit 0 is also clear, the write leaves the flags unchanged.
- R5: A control write with data bit 0 (software request) set sets the software-reset flag without raising `glob_rst_req`.
- R6: A write to the status offset (0x18) clears flag n when data bit n is 0 (n = 0 for watchdog, 1 for software reset). A data bit of 1 leaves that flag as it was, so software cannot set a flag.
- R7: When a set event and a clearing status write hit the same flag in the same cycle, the flag ends up set.
- R8: `bus_rdata` is registered. One edge after `bus_addr` presents 0x18, it shows the software-reset flag in bit 1, the watchdog flag in bit 0 and zeros above. Reading has no side effects.
- R9: The flags survive a raised `glob_rst_req` and any amount of idle time. Only a status write of 0 or `ext_rst` clears them.
- R10: Any address other than 0x14 and 0x18 reads as 0. Writes to such an address change neither flag nor `glob_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst | input | 1 | External chip reset, synchronous, active high |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_underflow | input | 1 | One-cycle watchdog/timer underflow event |
| glob_rst_req | output | 1 | One-cycle qualified global software reset request |

## Verification
A flag changes on the same edge that samples its event or write. Read data follows one edge after the address is presented, and the reset request is high during the single cycle after the control write edge. The bench drives every stimulus on the falling edge and lets one rising edge pass before it samples a flag. To read a flag, it presents the address and samples after the next rising edge, again at a falling edge. It checks the reset request in the cycle after the write and again one cycle later, which confirms the pulse lasts a single cycle.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    localparam int NUM_CAUSES = 2;
    localparam int CAUSE_WDT  = 0;
    localparam int CAUSE_GSW  = 1;

    localparam int CTL_SWREQ   = 0;
    localparam int CTL_COREEN  = 1;
    localparam int CTL_HOSTRST = 2;
    localparam int CTL_BITS    = 3;

    typedef struct packed {
        logic gsw;
        logic wdt;
    } cause_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2
    } sel_e;

    typedef struct packed {
        logic host_rst;
        logic core_en;
        logic sw_req;
    } ctl_req_t;

    function automatic ctl_req_t unpack_ctl(input logic [CTL_BITS-1:0] d);
        ctl_req_t r;
        r.sw_req   = d[CTL_SWREQ];
        r.core_en  = d[CTL_COREEN];
        r.host_rst = d[CTL_HOSTRST];
        return r;
    endfunction

    function automatic logic both_enables(input ctl_req_t r);
        return r.core_en & r.host_rst;
    endfunction

endpackage

// File: rtl/rst_cause_bus_dec.sv
module rst_cause_bus_dec
    import rst_cause_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h18,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output sel_e              sel,
    output logic              stat_wr,
    output logic              ctrl_wr
);
    always_comb begin
        if (addr == STAT_OFS)      sel = SEL_STAT;
        else if (addr == CTRL_OFS) sel = SEL_CTRL;
        else                       sel = SEL_NONE;
    end

    assign stat_wr = we && (sel == SEL_STAT);
    assign ctrl_wr = we && (sel == SEL_CTRL);
endmodule

// File: rtl/rst_cause_flag.sv
module rst_cause_flag (
    input  logic clk,
    input  logic ext_rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic q
);
    always_ff @(posedge clk) begin
        if (ext_rst)     q <= 1'b0;
        else if (set_ev) q <= 1'b1;
        else if (clr_ev) q <= 1'b0;
    end
endmodule

// File: rtl/rst_cause_gsw_qual.sv
module rst_cause_gsw_qual
    import rst_cause_pkg::*;
(
    input  logic                clk,
    input  logic                ext_rst,
    input  logic                ctrl_wr,
    input  logic [CTL_BITS-1:0] ctl_data,
    output logic                gsw_set,
    output logic                glob_rst_req
);
    ctl_req_t req;
    logic     fire;

    assign req     = unpack_ctl(ctl_data);
    assign fire    = ctrl_wr && both_enables(req);
    assign gsw_set = fire || (ctrl_wr && req.sw_req);

    always_ff @(posedge clk) begin
        if (ext_rst) glob_rst_req <= 1'b0;
        else         glob_rst_req <= fire;
    end
endmodule

// File: rtl/rst_cause_rdreg.sv
module rst_cause_rdreg
    import rst_cause_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              ext_rst,
    input  sel_e              sel,
    input  cause_t            causes,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - NUM_CAUSES;

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (sel == SEL_STAT) rd_next = {{PAD_W{1'b0}}, causes};
    end

    always_ff @(posedge clk) begin
        if (ext_rst) rdata <= '0;
        else         rdata <= rd_next;
    end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h18,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h14
) (
    input  logic              clk,
    input  logic              ext_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wdt_underflow,
    output logic              glob_rst_req
);
    sel_e                  sel;
    logic                  stat_wr;
    logic                  ctrl_wr;
    logic                  gsw_set;
    logic [NUM_CAUSES-1:0] set_vec;
    logic [NUM_CAUSES-1:0] clr_vec;
    logic [NUM_CAUSES-1:0] flags_q;
    cause_t                causes;
    logic                  unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTL_BITS];

    rst_cause_bus_dec #(
        .ADDR_W  (ADDR_W),
        .STAT_OFS(STAT_OFS),
        .CTRL_OFS(CTRL_OFS)
    ) u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .sel    (sel),
        .stat_wr(stat_wr),
        .ctrl_wr(ctrl_wr)
    );

    rst_cause_gsw_qual u_qual (
        .clk         (clk),
        .ext_rst     (ext_rst),
        .ctrl_wr     (ctrl_wr),
        .ctl_data    (bus_wdata[CTL_BITS-1:0]),
        .gsw_set     (gsw_set),
        .glob_rst_req(glob_rst_req)
    );

    assign set_vec[CAUSE_WDT] = wdt_underflow;
    assign set_vec[CAUSE_GSW] = gsw_set;

    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_flag
        assign clr_vec[i] = stat_wr && !bus_wdata[i];
        rst_cause_flag u_flag (
            .clk    (clk),
            .ext_rst(ext_rst),
            .set_ev (set_vec[i]),
            .clr_ev (clr_vec[i]),
            .q      (flags_q[i])
        );
    end

    assign causes.wdt = flags_q[CAUSE_WDT];
    assign causes.gsw = flags_q[CAUSE_GSW];

    rst_cause_rdreg #(.DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .ext_rst(ext_rst),
        .sel    (sel),
        .causes (causes),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h18,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h14
) (
    input logic              clk,
    input logic              ext_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wdt_underflow,
    input logic              glob_rst_req,
    input logic [1:0]        flags
);
    logic ctl_both;
    logic stat_clr0;
    assign ctl_both  = bus_we && bus_addr == CTRL_OFS && bus_wdata[1] && bus_wdata[2];
    assign stat_clr0 = bus_we && bus_addr == STAT_OFS && !bus_wdata[0];

    AST_WDT_SETS: assert property (@(posedge clk) disable iff (ext_rst)
        wdt_underflow |=> flags[0]); // R2
    AST_GRST_PULSE: assert property (@(posedge clk) disable iff (ext_rst)
        ctl_both |=> glob_rst_req && flags[1]); // R3
    AST_GRST_SINGLE: assert property (@(posedge clk) disable iff (ext_rst)
        glob_rst_req |=> !glob_rst_req); // R3
    AST_GRST_NEEDS_BOTH: assert property (@(posedge clk) disable iff (ext_rst)
        (!ctl_both && !ext_rst) |=> !glob_rst_req); // R4
    AST_NO_SW_SET_WDT: assert property (@(posedge clk) disable iff (ext_rst)
        (!flags[0] && !wdt_underflow) |=> !flags[0]); // R6
    AST_WDT_STICKY: assert property (@(posedge clk) disable iff (ext_rst)
        (flags[0] && !stat_clr0) |=> flags[0]); // R9
    AST_RDATA_STATUS: assert property (@(posedge clk) disable iff (ext_rst)
        ($past(!ext_rst) && $past(bus_addr) == STAT_OFS) |->
            bus_rdata == {{(DATA_W-2){1'b0}}, $past(flags)}); // R8
endmodule

bind rst_cause_reg rst_cause_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .STAT_OFS(STAT_OFS),
    .CTRL_OFS(CTRL_OFS)
) u_chk (
    .clk          (clk),
    .ext_rst      (ext_rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .wdt_underflow(wdt_underflow),
    .glob_rst_req (glob_rst_req),
    .flags        (flags_q)
);

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;
    localparam logic [7:0] STAT = 8'h18;
    localparam logic [7:0] CTRL = 8'h14;

    logic        clk = 1'b0;
    logic        ext_rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wdt_underflow;
    logic        glob_rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rst_cause_reg dut (
        .clk(clk), .ext_rst(ext_rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_underflow(wdt_underflow), .glob_rst_req(glob_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0; wdt_underflow = 1'b0; ext_rst = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic pulse_wdt();
        @(negedge clk);
        wdt_underflow = 1'b1;
        @(negedge clk);
        wdt_underflow = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ext_rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 glob_rst_req after reset", {31'b0, glob_rst_req}, 32'h0);
        bus_read(STAT, d);
        check("R1 flags after reset", d, 32'h0);
    endtask

    task automatic t_wdt();
        logic [31:0] d;
        pulse_wdt();
        bus_read(STAT, d);
        check("R2 watchdog flag set", d, 32'h1);
        repeat (5) idle();
        bus_read(STAT, d);
        check("R2 watchdog flag held", d, 32'h1);
    endtask

    task automatic t_grst_both();
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        bus_addr = CTRL; bus_we = 1'b1; bus_wdata = 32'h6;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        check("R3 request in cycle after write", {31'b0, glob_rst_req}, 32'h1);
        @(negedge clk);
        check("R3 request lasts one cycle", {31'b0, glob_rst_req}, 32'h0);
        bus_read(STAT, d);
        check("R3 software flag set", d, 32'h2);
        repeat (4) idle();
        bus_read(STAT, d);
        check("R9 flag survives request", d, 32'h2);
    endtask

    task automatic t_grst_partial();
        logic [31:0] d;
        do_reset();
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            bus_addr = CTRL; bus_we = 1'b1; bus_wdata = (k == 0) ? 32'h2 : 32'h4;
            @(negedge clk);
            bus_we = 1'b0; bus_wdata = '0;
            check("R4 no request with one enable", {31'b0, glob_rst_req}, 32'h0);
            @(negedge clk);
            check("R4 no request later", {31'b0, glob_rst_req}, 32'h0);
        end
        bus_read(STAT, d);
        check("R4 flags unchanged", d, 32'h0);
    endtask

    task automatic t_swreq();
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        bus_addr = CTRL; bus_we = 1'b1; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        check("R5 no request on software bit", {31'b0, glob_rst_req}, 32'h0);
        bus_read(STAT, d);
        check("R5 software flag set", d, 32'h2);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        pulse_wdt();
        bus_read(STAT, d);
        check("R6 both set before clear", d, 32'h3);
        bus_write(STAT, 32'hFFFF_FFFE);
        bus_read(STAT, d);
        check("R6 write 0 clears bit 0 only", d, 32'h2);
        bus_write(STAT, 32'hFFFF_FFFF);
        bus_read(STAT, d);
        check("R6 write 1 has no effect", d, 32'h2);
        bus_write(STAT, 32'h0);
        bus_read(STAT, d);
        check("R6 write 0 clears all", d, 32'h0);
        bus_write(STAT, 32'h3);
        bus_read(STAT, d);
        check("R6 software cannot set", d, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        bus_write(CTRL, 32'h1);
        @(negedge clk);
        bus_addr = STAT; bus_we = 1'b1; bus_wdata = 32'h0; wdt_underflow = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; wdt_underflow = 1'b0;
        bus_read(STAT, d);
        check("R7 set wins over clear", d, 32'h1);
    endtask

    task automatic t_read_other();
        logic [31:0] d;
        pulse_wdt();
        bus_write(CTRL, 32'h1);
        bus_read(8'h1C, d);
        check("R10 other address reads 0", d, 32'h0);
        bus_read(CTRL, d);
        check("R10 control offset reads 0", d, 32'h0);
        bus_read(STAT, d);
        check("R8 first status read", d, 32'h3);
        bus_read(STAT, d);
        check("R8 read has no side effect", d, 32'h3);
    endtask

    task automatic t_write_other();
        logic [31:0] d;
        bus_write(8'h1C, 32'h0);
        bus_write(8'h00, 32'h0);
        bus_read(STAT, d);
        check("R10 foreign write leaves flags", d, 32'h3);
        @(negedge clk);
        bus_addr = 8'h20; bus_we = 1'b1; bus_wdata = 32'h6;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        check("R10 foreign write no request", {31'b0, glob_rst_req}, 32'h0);
        do_reset();
        bus_read(STAT, d);
        check("R9 external reset clears both", d, 32'h0);
    endtask

    initial begin
        ext_rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; wdt_underflow = 1'b0;
        t_reset();
        t_wdt();
        t_grst_both();
        t_grst_partial();
        t_swreq();
        t_clear();
        t_collide();
        t_read_other();
        t_write_other();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule